// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This block records the moment a qualifying frame crosses the timestamp point of a network port. It has two independent channels, one for transmit and one for receive. When a channel is enabled and its qualify strobe arrives, the 64-bit time value present on that same cycle is copied into the channel's capture register and the channel's valid flag goes high. From then on the channel is locked: further strobes are dropped and counted in a sticky, saturating missed-event counter. The lock is released only when software reads the high 32-bit word of the capture. A read of the high word with no interest in the data, as done during hang recovery, releases it just the same.

Software reads the capture through a small read port. Reading the low word leaves the channel untouched. Each channel can raise a one-cycle interrupt pulse on capture, and this pulse can be masked. The receive channel also has a per-packet mode. In that mode the stamp is not held in the register. Instead it is streamed as four little-endian 32-bit dwords into the start of the frame's first receive buffer. The frame classifier that drives the qualify strobes lies outside this block.

Top module: `ts_capture_top`

## Requirements
- R1: With its enable set and its channel unlocked, a qualify strobe copies the time value present on that strobe's clock cycle into the channel's capture, and the valid flag reads 1 from the next cycle.
- R2: While a channel's enable is 0, its strobes have no effect: valid stays 0 and the missed counter is unchanged.
- R3: While valid is 1, strobes capture nothing and the stored stamp does not change.
- R4: A read at address 1 (transmit high) or 3 (receive high) returns bits 63:32 of that channel's stamp one cycle after the read request and clears valid in the same cycle. The next strobe is then captured.
- R5: A read at address 0 (transmit low) or 2 (receive low) returns bits 31:0 one cycle after the request and leaves valid and the lock unchanged.
- R6: Every strobe dropped by an enabled but locked channel adds one to that channel's missed counter. The counter saturates at its all-ones value and clears only on reset.
- R7: The two channels are independent: captures, reads and drops on one never change the other's valid flag, stamp or counter.
- R8: When a stamp is accepted and the channel's interrupt enable is 1, the interrupt output pulses high for exactly the one cycle after the strobe. With the interrupt enable at 0 it stays low.
- R9: In receive per-packet mode, an accepted receive strobe leaves receive valid at 0. Starting two cycles after the strobe, it emits four consecutive buffer writes with dword index 0, 1, 2, 3 (byte offset 4 times the index). The data is 0, 0, stamp bits 31:0, then stamp bits 63:32.
- R10: In per-packet mode, a receive strobe arriving while the four writes are still pending is dropped and counted as missed.
- R11: After reset, both valid flags, both missed counters, both interrupt outputs and the buffer write enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current time value |
| tx_en | input | 1 | Transmit channel enable |
| rx_en | input | 1 | Receive channel enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rx_pkt_mode | input | 1 | Receive stamp goes to the buffer instead of the register |
| tx_qual | input | 1 | Transmit frame at timestamp point |
| rx_qual | input | 1 | Receive frame at timestamp point |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | 0 tx low, 1 tx high, 2 rx low, 3 rx high |
| rd_data | output | 32 | Read data, one cycle after request |
| tx_valid | output | 1 | Transmit capture held |
| rx_valid | output | 1 | Receive capture held |
| tx_miss | output | MISS_W | Transmit missed-event count |
| rx_miss | output | MISS_W | Receive missed-event count |
| tx_irq | output | 1 | Transmit capture interrupt pulse |
| rx_irq | output | 1 | Receive capture interrupt pulse |
| bwr_en | output | 1 | Buffer dword write strobe |
| bwr_dw | output | 2 | Dword index within the buffer |
| bwr_data | output | 32 | Buffer dword, little-endian byte lanes |

## Verification
The assertions check on every cycle that valid rises only after an enabled strobe, that a held stamp never changes until a high read, that a high read always drops valid, that the missed counters never decrease, that interrupts follow accepted stamps only, and that buffer writes step through dword indices in order. Only the bench's scenarios can show that the right time value was taken, that low reads leave the lock alone, that channels do not disturb each other, that the counter saturates at the right value, and that the buffer dwords carry zero, zero, low and high.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int WORD_W = 32;
  localparam int NCHAN  = 2;
  localparam int CH_TX  = 0;
  localparam int CH_RX  = 1;

  typedef enum logic [1:0] {
    RA_TX_LO = 2'd0,
    RA_TX_HI = 2'd1,
    RA_RX_LO = 2'd2,
    RA_RX_HI = 2'd3
  } ts_addr_e;
endpackage

// File: rtl/ts_chan.sv
module ts_chan #(
  parameter int TIME_W = 64,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              irq_en,
  input  logic              pkt_mode,
  input  logic              pkt_busy,
  input  logic              qual,
  input  logic [TIME_W-1:0] time_now,
  input  logic              rd_hi,
  output logic              valid,
  output logic [TIME_W-1:0] stamp,
  output logic [MISS_W-1:0] miss,
  output logic              irq,
  output logic              pkt_go
);
  logic locked, take, drop, cap_reg;

  assign locked  = valid | (pkt_mode & pkt_busy);
  assign take    = qual & en & ~locked;
  assign drop    = qual & en & locked;
  assign cap_reg = take & ~pkt_mode;
  assign pkt_go  = take & pkt_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      stamp <= '0;
      miss  <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= take & irq_en;
      if (valid && rd_hi) begin
        valid <= 1'b0;
      end else if (cap_reg) begin
        valid <= 1'b1;
        stamp <= time_now;
      end
      if (drop && (miss != {MISS_W{1'b1}})) begin
        miss <= miss + 1'b1;
      end
    end
  end

  // R1
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(qual && en && !pkt_mode));
  // R3
  hold_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !rd_hi) |=> (valid && $stable(stamp)));
  // R4
  hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && rd_hi) |=> !valid);
  // R6
  miss_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (miss >= $past(miss)));
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en && qual && en));
endmodule

// File: rtl/ts_pktwr.sv
module ts_pktwr #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [2*WORD_W-1:0] time_in,
  output logic                busy,
  output logic                bwr_en,
  output logic [1:0]          bwr_dw,
  output logic [WORD_W-1:0]   bwr_data
);
  logic [2*WORD_W-1:0] held;
  logic [1:0]          beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      beat     <= '0;
      held     <= '0;
      bwr_en   <= 1'b0;
      bwr_dw   <= '0;
      bwr_data <= '0;
    end else begin
      bwr_en <= busy;
      if (busy) begin
        bwr_dw <= beat;
        case (beat)
          2'd2:    bwr_data <= held[WORD_W-1:0];
          2'd3:    bwr_data <= held[2*WORD_W-1:WORD_W];
          default: bwr_data <= '0;
        endcase
        beat <= beat + 1'b1;
        if (beat == 2'd3) busy <= 1'b0;
      end else if (go) begin
        busy <= 1'b1;
        beat <= '0;
        held <= time_in;
      end
    end
  end

  // R9
  beat_order_chk: assert property (@(posedge clk) disable iff (rst)
    (bwr_en && bwr_dw != 2'd3) |=> (bwr_en && bwr_dw == $past(bwr_dw) + 2'd1));
  // R9
  beat_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bwr_en) |-> (bwr_dw == 2'd0));
  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bwr_en && bwr_dw[1] == 1'b0) |-> (bwr_data == '0));
endmodule

// File: rtl/ts_capture_top.sv
module ts_capture_top
  import ts_pkg::*;
#(
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       time_now,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_irq_en,
  input  logic              rx_irq_en,
  input  logic              rx_pkt_mode,
  input  logic              tx_qual,
  input  logic              rx_qual,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              tx_valid,
  output logic              rx_valid,
  output logic [MISS_W-1:0] tx_miss,
  output logic [MISS_W-1:0] rx_miss,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              bwr_en,
  output logic [1:0]        bwr_dw,
  output logic [31:0]       bwr_data
);
  localparam int TIME_W = 2 * WORD_W;

  logic [NCHAN-1:0]              c_en, c_irq_en, c_pmode, c_qual, c_rdhi;
  logic [NCHAN-1:0]              c_valid, c_irq, c_go;
  logic [NCHAN-1:0][TIME_W-1:0]  c_stamp;
  logic [NCHAN-1:0][MISS_W-1:0]  c_miss;
  logic                          pk_busy;

  assign c_en     = {rx_en, tx_en};
  assign c_irq_en = {rx_irq_en, tx_irq_en};
  assign c_pmode  = {rx_pkt_mode, 1'b0};
  assign c_qual   = {rx_qual, tx_qual};
  assign c_rdhi   = {rd_en && (rd_addr == RA_RX_HI), rd_en && (rd_addr == RA_TX_HI)};

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    ts_chan #(.TIME_W(TIME_W), .MISS_W(MISS_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .en       (c_en[c]),
      .irq_en   (c_irq_en[c]),
      .pkt_mode (c_pmode[c]),
      .pkt_busy (pk_busy),
      .qual     (c_qual[c]),
      .time_now (time_now),
      .rd_hi    (c_rdhi[c]),
      .valid    (c_valid[c]),
      .stamp    (c_stamp[c]),
      .miss     (c_miss[c]),
      .irq      (c_irq[c]),
      .pkt_go   (c_go[c])
    );
  end

  ts_pktwr #(.WORD_W(WORD_W)) u_pktwr (
    .clk      (clk),
    .rst      (rst),
    .go       (c_go[CH_RX]),
    .time_in  (time_now),
    .busy     (pk_busy),
    .bwr_en   (bwr_en),
    .bwr_dw   (bwr_dw),
    .bwr_data (bwr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        RA_TX_LO: rd_data <= c_stamp[CH_TX][WORD_W-1:0];
        RA_TX_HI: rd_data <= c_stamp[CH_TX][TIME_W-1:WORD_W];
        RA_RX_LO: rd_data <= c_stamp[CH_RX][WORD_W-1:0];
        default:  rd_data <= c_stamp[CH_RX][TIME_W-1:WORD_W];
      endcase
    end
  end

  assign tx_valid = c_valid[CH_TX];
  assign rx_valid = c_valid[CH_RX];
  assign tx_miss  = c_miss[CH_TX];
  assign rx_miss  = c_miss[CH_RX];
  assign tx_irq   = c_irq[CH_TX];
  assign rx_irq   = c_irq[CH_RX];

  // R9
  pkt_no_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_pkt_mode && !rx_valid) |=> !rx_valid);
  // R7
  tx_iso_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !(rd_en && rd_addr == RA_TX_HI)) |=> tx_valid);
endmodule

// File: tb/ts_capture_top_tb.sv
module ts_capture_top_tb;
  localparam int MW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] time_now = 64'hA5A5_0001_FFFF_FF00;
  logic tx_en = 0, rx_en = 0, tx_irq_en = 0, rx_irq_en = 0, rx_pkt_mode = 0;
  logic tx_qual = 0, rx_qual = 0, rd_en = 0;
  logic [1:0] rd_addr = 0;
  logic [31:0] rd_data, bwr_data;
  logic tx_valid, rx_valid, tx_irq, rx_irq, bwr_en;
  logic [MW-1:0] tx_miss, rx_miss;
  logic [1:0] bwr_dw;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_txm = 0, exp_rxm = 0;

  ts_capture_top #(.MISS_W(MW)) u_dut (
    .clk(clk), .rst(rst), .time_now(time_now), .tx_en(tx_en), .rx_en(rx_en),
    .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .rx_pkt_mode(rx_pkt_mode),
    .tx_qual(tx_qual), .rx_qual(rx_qual), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .tx_valid(tx_valid), .rx_valid(rx_valid),
    .tx_miss(tx_miss), .rx_miss(rx_miss), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .bwr_en(bwr_en), .bwr_dw(bwr_dw), .bwr_data(bwr_data));

  always #10 clk = ~clk;
  always @(posedge clk) time_now <= time_now + 64'd8;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit rx, output logic [63:0] t);
    @(negedge clk);
    if (rx) rx_qual = 1; else tx_qual = 1;
    t = time_now;
    @(negedge clk);
    rx_qual = 0; tx_qual = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic t_reset;
    check("R11 tx_valid", tx_valid, 0);
    check("R11 rx_valid", rx_valid, 0);
    check("R11 misses", {tx_miss, rx_miss}, 0);
    check("R11 irq", {tx_irq, rx_irq}, 0);
    check("R11 bwr_en", bwr_en, 0);
  endtask

  task automatic t_basic;
    logic [63:0] t; logic [31:0] d;
    tx_en = 1; tx_irq_en = 1;
    strobe(0, t);
    check("R1 tx_valid", tx_valid, 1);
    check("R8 irq pulse", tx_irq, 1);
    @(negedge clk);
    check("R8 irq one cycle", tx_irq, 0);
    rd(2'd0, d);
    check("R5 lo data", d, t[31:0]);
    check("R5 valid kept", tx_valid, 1);
    rd(2'd1, d);
    check("R4 hi data", d, t[63:32]);
    check("R4 valid cleared", tx_valid, 0);
  endtask

  task automatic t_lock;
    logic [63:0] a, b, c; logic [31:0] d;
    strobe(0, a);
    repeat (3) @(negedge clk);
    strobe(0, b); exp_txm++;
    check("R6 miss count", tx_miss, exp_txm);
    rd(2'd0, d);
    check("R3 lo unchanged", d, a[31:0]);
    rd(2'd1, d);
    check("R3 hi unchanged", d, a[63:32]);
    strobe(0, c);
    check("R4 relock", tx_valid, 1);
    rd(2'd1, d);
    check("R4 new hi", d, c[63:32]);
    check("R1 new stamp differs", (c != a), 1);
  endtask

  task automatic t_disable;
    logic [63:0] t;
    tx_en = 0;
    strobe(0, t);
    check("R2 no capture", tx_valid, 0);
    check("R2 no miss", tx_miss, exp_txm);
    strobe(0, t); tx_en = 1;
    check("R2 still none", tx_valid, 0);
  endtask

  task automatic t_indep;
    logic [63:0] tt, tr; logic [31:0] d;
    rx_en = 1; rx_irq_en = 0;
    strobe(0, tt);
    repeat (2) @(negedge clk);
    strobe(1, tr);
    check("R8 masked irq", rx_irq, 0);
    check("R7 both valid", {tx_valid, rx_valid}, 2'b11);
    rd(2'd3, d);
    check("R7 rx hi", d, tr[63:32]);
    check("R7 tx kept", {tx_valid, rx_valid}, 2'b10);
    rd(2'd2, d);
    check("R7 rx lo", d, tr[31:0]);
    rd(2'd0, d);
    check("R7 tx lo", d, tt[31:0]);
    check("R7 rx miss", rx_miss, exp_rxm);
  endtask

  task automatic t_sat;
    logic [63:0] t; logic [31:0] d;
    for (int i = 0; i < 20; i++) begin
      strobe(0, t);
      exp_txm = (exp_txm < 15) ? exp_txm + 1 : 15;
    end
    check("R6 saturated", tx_miss, 15);
    rd(2'd1, d);
    check("R6 sticky after read", tx_miss, 15);
    check("R7 rx untouched", rx_miss, exp_rxm);
  endtask

  task automatic t_pkt;
    logic [63:0] t; logic [31:0] exp_d [4];
    rx_pkt_mode = 1; rx_irq_en = 1;
    @(negedge clk);
    rx_qual = 1; t = time_now;
    @(negedge clk);
    rx_qual = 1;
    @(negedge clk);
    rx_qual = 0; exp_rxm++;
    check("R10 busy drop", rx_miss, exp_rxm);
    exp_d[0] = 0; exp_d[1] = 0; exp_d[2] = t[31:0]; exp_d[3] = t[63:32];
    for (int k = 0; k < 4; k++) begin
      check("R9 write en", bwr_en, 1);
      check("R9 dword index", bwr_dw, k);
      check("R9 dword data", bwr_data, exp_d[k]);
      @(negedge clk);
    end
    check("R9 writes end", bwr_en, 0);
    check("R9 rx reg not set", rx_valid, 0);
    rx_pkt_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lock();
    t_disable();
    t_indep();
    t_sat();
    t_pkt();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule